// File: doc/BRIEF.md
# DRAM Range and Node Interleave Decoder

This block takes a 48-bit physical system address and works out which of a set of programmable DRAM ranges owns it, and so which destination node the access belongs to. Each range has its own enable, base, inclusive limit, node ID and node-interleave setting. Ranges are compared in parallel and the lowest-numbered hit wins. On a hit the block reports the node ID, the number of address bits consumed by node interleaving, the index of the winning range and the address after an optional swap remap of a low region. On a miss it raises an out-of-bounds flag.

Configuration arrives on a simple write port: an index, a word selector and a 32-bit data word. A decode request is a valid strobe with an address; the result appears one clock later with its own valid strobe. A sticky error flag reports that software wrote an interleave mask the decoder cannot use.

Top module: `dram_range_decoder`

## Requirements
- R1: A range takes part in decoding only when its 2-bit enable field (base word bits [29:28]) is nonzero; a range with enable 0 never hits.
- R2: The base word carries address bits [39:24] in bits [15:0] and address bits [47:40] in bits [23:16], with address bits [23:0] of the base taken as zero; the limit word uses the same placement with address bits [23:0] taken as all ones, so both ends are inclusive.
- R3: With a nonzero interleave mask (base word bits [26:24]) a range hits only if its interleave select (limit word bits [26:24]) equals address bits [14:12] ANDed with the mask; a zero mask skips this test.
- R4: On a hit, out_node is the node field of the winning range (limit word bits [30:28]) and out_ilv_bits is 0, 1, 2 or 3 for masks 0, 1, 3 or 7.
- R5: When several ranges hit, the lowest index wins and out_range reports that index.
- R6: The swap word (cfg_sel 2) holds enable in bit 0, swap base in bits [14:8], swap limit in bits [22:16] and swap size in bits [30:24]. On a hit with swap enabled and address bits [47:34] all zero, if address bits [33:27] lie between swap base and swap limit inclusive or are below swap size, out_addr is the address XOR (swap base shifted left by 27); otherwise out_addr equals the input address.
- R7: On a miss out_oob is 1, out_hit is 0, out_node, out_ilv_bits and out_range are 0 and out_addr equals the input address; out_hit and out_oob are never both set or both clear with out_valid.
- R8: Writing an interleave mask other than 0, 1, 3 or 7 sets cfg_err, which stays set until reset, and the range then behaves as if its mask were 0.
- R9: out_valid is in_valid delayed by exactly one clock, and the result fields belong to the address presented with that in_valid.
- R10: After reset out_valid and cfg_err are 0, every range is disabled and swapping is off, so any decode misses.
- R11: cfg_sel 0 writes the base word and 1 the limit word of range cfg_idx; a write is seen by decodes presented in later cycles only, so a decode in the same cycle as a write uses the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDXW | Range index for base/limit writes |
| cfg_sel | input | 2 | Word select: 0 base, 1 limit, 2 swap, 3 ignored |
| cfg_wdata | input | 32 | Configuration word |
| cfg_err | output | 1 | Sticky illegal interleave mask flag |
| in_valid | input | 1 | Decode request strobe |
| in_addr | input | 48 | System address to decode |
| out_valid | output | 1 | Decode result strobe |
| out_hit | output | 1 | Address matched a range |
| out_oob | output | 1 | Address matched no range |
| out_node | output | 3 | Destination node ID |
| out_ilv_bits | output | 2 | Node interleave bit count |
| out_range | output | IDXW | Index of the winning range |
| out_addr | output | 48 | Address after swap remap |

## Verification
Every decode result is due in the clock after the one that samples in_valid, so the bench drives a request on a falling edge and checks all result fields on the next falling edge, after exactly one rising edge. Configuration writes are driven the same way and the reference model is updated only after the result of any decode sharing that cycle has been checked, which keeps the bench on the old-configuration rule. The cycle after a request is dropped is checked for a low out_valid.

// File: rtl/dram_range_decoder.sv
module dram_range_decoder #(
  parameter int NUM_RANGES = 8,
  localparam int IDXW = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [IDXW-1:0] cfg_idx,
  input  logic [1:0]      cfg_sel,
  input  logic [31:0]     cfg_wdata,
  output logic            cfg_err,
  input  logic            in_valid,
  input  logic [47:0]     in_addr,
  output logic            out_valid,
  output logic            out_hit,
  output logic            out_oob,
  output logic [2:0]      out_node,
  output logic [1:0]      out_ilv_bits,
  output logic [IDXW-1:0] out_range,
  output logic [47:0]     out_addr
);

  logic [1:0]  r_en   [NUM_RANGES];
  logic [2:0]  r_mask [NUM_RANGES];
  logic [23:0] r_base [NUM_RANGES];
  logic [23:0] r_lim  [NUM_RANGES];
  logic [2:0]  r_isel [NUM_RANGES];
  logic [2:0]  r_node [NUM_RANGES];

  logic        sw_en;
  logic [6:0]  sw_base, sw_lim, sw_size;

  logic [NUM_RANGES-1:0] hit_vec;
  logic                  found;
  logic [IDXW-1:0]       win;
  logic [1:0]            ilv_bits;
  logic                  swap_cond;
  logic [47:0]           addr_next;
  logic [6:0]            region;

  wire [2:0] wmask      = cfg_wdata[26:24];
  wire       mask_legal = (wmask == 3'd0) || (wmask == 3'd1) || (wmask == 3'd3) || (wmask == 3'd7);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_RANGES; i++) begin
        r_en[i]   <= '0;
        r_mask[i] <= '0;
        r_base[i] <= '0;
        r_lim[i]  <= '0;
        r_isel[i] <= '0;
        r_node[i] <= '0;
      end
      sw_en   <= 1'b0;
      sw_base <= '0;
      sw_lim  <= '0;
      sw_size <= '0;
      cfg_err <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_sel == 2'd2) begin
        sw_en   <= cfg_wdata[0];
        sw_base <= cfg_wdata[14:8];
        sw_lim  <= cfg_wdata[22:16];
        sw_size <= cfg_wdata[30:24];
      end else if (int'(cfg_idx) < NUM_RANGES) begin
        if (cfg_sel == 2'd0) begin
          r_en[cfg_idx]   <= cfg_wdata[29:28];
          r_mask[cfg_idx] <= mask_legal ? wmask : 3'd0;
          r_base[cfg_idx] <= cfg_wdata[23:0];
          if (!mask_legal) cfg_err <= 1'b1;
        end else if (cfg_sel == 2'd1) begin
          r_node[cfg_idx] <= cfg_wdata[30:28];
          r_isel[cfg_idx] <= cfg_wdata[26:24];
          r_lim[cfg_idx]  <= cfg_wdata[23:0];
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_cmp
    wire [47:0] lo = {r_base[g], 24'h000000};
    wire [47:0] hi = {r_lim[g], 24'hFFFFFF};
    wire        il = (r_mask[g] == 3'd0) || (r_isel[g] == (in_addr[14:12] & r_mask[g]));
    assign hit_vec[g] = (r_en[g] != 2'd0) && (in_addr >= lo) && (in_addr <= hi) && il;
  end

  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int i = NUM_RANGES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        found = 1'b1;
        win   = IDXW'(i);
      end
    end
  end

  always_comb begin
    case (r_mask[win])
      3'd1:    ilv_bits = 2'd1;
      3'd3:    ilv_bits = 2'd2;
      3'd7:    ilv_bits = 2'd3;
      default: ilv_bits = 2'd0;
    endcase
  end

  assign region    = in_addr[33:27];
  assign swap_cond = sw_en && (in_addr[47:34] == '0) &&
                     (((region >= sw_base) && (region <= sw_lim)) || (region < sw_size));
  assign addr_next = (found && swap_cond) ? (in_addr ^ {14'd0, sw_base, 27'd0}) : in_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_hit      <= 1'b0;
      out_oob      <= 1'b0;
      out_node     <= '0;
      out_ilv_bits <= '0;
      out_range    <= '0;
      out_addr     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_hit      <= found;
        out_oob      <= !found;
        out_node     <= found ? r_node[win] : 3'd0;
        out_ilv_bits <= found ? ilv_bits : 2'd0;
        out_range    <= found ? win : '0;
        out_addr     <= addr_next;
      end
    end
  end

endmodule

// File: rtl/dram_range_decoder_chk.sv
module dram_range_decoder_chk #(
  parameter int NUM_RANGES = 8,
  localparam int IDXW = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_err,
  input logic            in_valid,
  input logic [47:0]     in_addr,
  input logic            out_valid,
  input logic            out_hit,
  input logic            out_oob,
  input logic [2:0]      out_node,
  input logic [1:0]      out_ilv_bits,
  input logic [IDXW-1:0] out_range,
  input logic [47:0]     out_addr
);

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R9
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R7
  hit_oob_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_hit != out_oob));

  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_oob) |-> (out_node == 3'd0 && out_ilv_bits == 2'd0 && out_range == '0));

  // R7
  miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid ##1 out_oob |-> out_addr == $past(in_addr));

  // R6
  swap_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid ##1 out_hit |-> (out_addr[47:34] == $past(in_addr[47:34]) &&
                              out_addr[26:0] == $past(in_addr[26:0])));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

endmodule

bind dram_range_decoder dram_range_decoder_chk #(.NUM_RANGES(NUM_RANGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_err(cfg_err), .in_valid(in_valid), .in_addr(in_addr),
  .out_valid(out_valid), .out_hit(out_hit), .out_oob(out_oob), .out_node(out_node),
  .out_ilv_bits(out_ilv_bits), .out_range(out_range), .out_addr(out_addr)
);

// File: tb/dram_range_decoder_tb.sv
module dram_range_decoder_tb;
  localparam int NR = 8;
  localparam int IW = 3;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [IW-1:0] cfg_idx = '0;
  logic [1:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic cfg_err;
  logic in_valid = 0;
  logic [47:0] in_addr = '0;
  logic out_valid, out_hit, out_oob;
  logic [2:0] out_node;
  logic [1:0] out_ilv_bits;
  logic [IW-1:0] out_range;
  logic [47:0] out_addr;

  dram_range_decoder #(.NUM_RANGES(NR)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_err(cfg_err), .in_valid(in_valid), .in_addr(in_addr),
    .out_valid(out_valid), .out_hit(out_hit), .out_oob(out_oob), .out_node(out_node),
    .out_ilv_bits(out_ilv_bits), .out_range(out_range), .out_addr(out_addr));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [1:0]  m_en [NR];
  logic [2:0]  m_mask [NR], m_isel [NR], m_node [NR];
  logic [7:0]  m_bhi [NR], m_lhi [NR];
  logic [15:0] m_blo [NR], m_llo [NR];
  logic        s_en, m_err;
  logic [6:0]  s_base, s_lim, s_size;

  logic e_hit;
  logic [2:0] e_node;
  logic [1:0] e_ilv;
  logic [IW-1:0] e_range;
  logic [47:0] e_addr;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] base_w(logic [1:0] en, logic [2:0] m, logic [7:0] hi, logic [15:0] lo);
    return {2'b00, en, 1'b0, m, hi, lo};
  endfunction
  function automatic logic [31:0] lim_w(logic [2:0] nd, logic [2:0] s, logic [7:0] hi, logic [15:0] lo);
    return {1'b0, nd, 1'b0, s, hi, lo};
  endfunction
  function automatic logic [31:0] swap_w(logic en, logic [6:0] b, logic [6:0] l, logic [6:0] sz);
    return {1'b0, sz, 1'b0, l, 1'b0, b, 7'd0, en};
  endfunction

  function automatic bit legal(logic [2:0] m);
    return m == 0 || m == 1 || m == 3 || m == 7;
  endfunction

  function automatic void model(input logic [47:0] a);
    logic [47:0] lo, hi;
    logic [2:0] m;
    logic [6:0] rg;
    e_hit = 0; e_node = 0; e_ilv = 0; e_range = 0; e_addr = a;
    for (int i = 0; i < NR; i++) begin
      if (!e_hit) begin
        lo = {m_bhi[i], m_blo[i], 24'h0};
        hi = {m_lhi[i], m_llo[i], 24'hFFFFFF};
        m  = legal(m_mask[i]) ? m_mask[i] : 3'd0;
        if (m_en[i] != 0 && a >= lo && a <= hi && (m == 0 || m_isel[i] == (a[14:12] & m))) begin
          e_hit = 1; e_range = IW'(i); e_node = m_node[i];
          e_ilv = (m == 7) ? 2'd3 : (m == 3) ? 2'd2 : (m == 1) ? 2'd1 : 2'd0;
        end
      end
    end
    rg = a[33:27];
    if (e_hit && s_en && a[47:34] == 0 && ((rg >= s_base && rg <= s_lim) || rg < s_size))
      e_addr = a ^ ({41'd0, s_base} << 27);
  endfunction

  function automatic void apply(input logic [IW-1:0] idx, input logic [1:0] sel, input logic [31:0] d);
    if (sel == 0) begin
      m_en[idx] = d[29:28]; m_mask[idx] = d[26:24]; m_bhi[idx] = d[23:16]; m_blo[idx] = d[15:0];
      if (!legal(d[26:24])) m_err = 1;
    end else if (sel == 1) begin
      m_node[idx] = d[30:28]; m_isel[idx] = d[26:24]; m_lhi[idx] = d[23:16]; m_llo[idx] = d[15:0];
    end else if (sel == 2) begin
      s_en = d[0]; s_base = d[14:8]; s_lim = d[22:16]; s_size = d[30:24];
    end
  endfunction

  task automatic wr(input logic [IW-1:0] idx, input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_idx = idx; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    apply(idx, sel, d);
  endtask

  task automatic check_result(input string req);
    chk(out_valid == 1, "R9", {req, " valid"}, out_valid, 1);
    chk(out_hit == e_hit, req, "hit", out_hit, e_hit);
    chk(out_oob == !e_hit, req, "oob", out_oob, !e_hit);
    chk(out_node == e_node, req, "node", out_node, e_node);
    chk(out_ilv_bits == e_ilv, req, "ilv bits", out_ilv_bits, e_ilv);
    chk(out_range == e_range, req, "range", out_range, e_range);
    chk(out_addr == e_addr, req, "addr", out_addr, e_addr);
  endtask

  task automatic dec(input logic [47:0] a, input string req);
    @(negedge clk);
    in_valid = 1; in_addr = a;
    model(a);
    @(negedge clk);
    in_valid = 0;
    check_result(req);
  endtask

  // R11: write and decode in the same cycle; model updated after the check
  task automatic wr_dec(input logic [IW-1:0] idx, input logic [1:0] sel, input logic [31:0] d,
                        input logic [47:0] a);
    @(negedge clk);
    cfg_we = 1; cfg_idx = idx; cfg_sel = sel; cfg_wdata = d;
    in_valid = 1; in_addr = a;
    model(a);
    @(negedge clk);
    cfg_we = 0; in_valid = 0;
    check_result("R11");
    apply(idx, sel, d);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NR; i++) begin
      m_en[i] = 0; m_mask[i] = 0; m_isel[i] = 0; m_node[i] = 0;
      m_bhi[i] = 0; m_lhi[i] = 0; m_blo[i] = 0; m_llo[i] = 0;
    end
    s_en = 0; s_base = 0; s_lim = 0; s_size = 0; m_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10
    chk(out_valid == 0, "R10", "out_valid after reset", out_valid, 0);
    chk(cfg_err == 0, "R10", "cfg_err after reset", cfg_err, 0);
    dec(48'h0000_0000_0000, "R10");
    dec(48'h0012_3456_7890, "R10");

    // R1
    wr(2, 0, base_w(2'd0, 3'd0, 8'h00, 16'h0010));
    wr(2, 1, lim_w(3'd5, 3'd0, 8'h00, 16'h0020));
    dec(48'h0000_1500_0000, "R1");
    wr(2, 0, base_w(2'd1, 3'd0, 8'h00, 16'h0010));
    dec(48'h0000_1500_0000, "R1");

    // R2
    dec(48'h0000_1000_0000, "R2");
    dec(48'h0000_0FFF_FFFF, "R2");
    dec(48'h0000_20FF_FFFF, "R2");
    dec(48'h0000_2100_0000, "R2");
    wr(6, 0, base_w(2'd3, 3'd0, 8'hA5, 16'h1234));
    wr(6, 1, lim_w(3'd7, 3'd0, 8'hA5, 16'h1234));
    dec(48'hA512_3400_0000, "R2");
    dec(48'hA512_34FF_FFFF, "R2");
    dec(48'hA512_3500_0000, "R2");

    // R3 R4
    wr(4, 0, base_w(2'd1, 3'd3, 8'h00, 16'h0100));
    wr(4, 1, lim_w(3'd3, 3'd2, 8'h00, 16'h01FF));
    dec(48'h0001_0000_2000, "R3");
    dec(48'h0001_0000_1000, "R3");
    dec(48'h0001_0000_6000, "R4");
    wr(4, 0, base_w(2'd1, 3'd7, 8'h00, 16'h0100));
    wr(4, 1, lim_w(3'd3, 3'd5, 8'h00, 16'h01FF));
    dec(48'h0001_0000_5000, "R4");
    dec(48'h0001_0000_4000, "R3");
    wr(4, 0, base_w(2'd1, 3'd1, 8'h00, 16'h0100));
    wr(4, 1, lim_w(3'd3, 3'd1, 8'h00, 16'h01FF));
    dec(48'h0001_0000_1000, "R4");

    // R5
    wr(1, 0, base_w(2'd2, 3'd0, 8'h00, 16'h0180));
    wr(1, 1, lim_w(3'd6, 3'd0, 8'h00, 16'h0190));
    dec(48'h0001_8000_1000, "R5");
    dec(48'h0001_9100_1000, "R5");

    // R6
    wr(0, 0, base_w(2'd1, 3'd0, 8'h00, 16'h0000));
    wr(0, 1, lim_w(3'd4, 3'd0, 8'h00, 16'h03FF));
    wr(3, 0, base_w(2'd1, 3'd0, 8'h00, 16'h0400));
    wr(3, 1, lim_w(3'd1, 3'd0, 8'h00, 16'h04FF));
    wr(0, 2, swap_w(1'b1, 7'd2, 7'd3, 7'd2));
    dec(48'h0000_1000_0123, "R6");
    dec(48'h0000_0800_0040, "R6");
    dec(48'h0000_2800_0000, "R6");
    dec(48'h0004_1000_0000, "R6");
    dec(48'h0000_9000_0000, "R7");

    // R8
    wr(5, 0, base_w(2'd1, 3'd5, 8'h08, 16'h0000));
    wr(5, 1, lim_w(3'd2, 3'd1, 8'h08, 16'h00FF));
    chk(cfg_err == 1, "R8", "cfg_err after illegal mask", cfg_err, 1);
    dec(48'h0800_0000_0000, "R8");
    wr(5, 0, base_w(2'd1, 3'd0, 8'h08, 16'h0000));
    chk(cfg_err == 1, "R8", "cfg_err sticky", cfg_err, 1);

    // R11
    wr_dec(5, 0, base_w(2'd0, 3'd0, 8'h08, 16'h0000), 48'h0800_0000_0000);
    dec(48'h0800_0000_0000, "R11");

    // R9
    @(negedge clk);
    chk(out_valid == 0, "R9", "out_valid after idle", out_valid, 0);

    // random mix
    for (int n = 0; n < 600; n++) begin
      if (($urandom % 8) == 0) begin
        logic [IW-1:0] idx;
        logic [2:0] mk;
        logic [15:0] blo;
        idx = IW'($urandom % NR);
        case ($urandom % 5)
          0: mk = 3'd0; 1: mk = 3'd1; 2: mk = 3'd3; 3: mk = 3'd7;
          default: mk = 3'($urandom);
        endcase
        blo = 16'($urandom % 1024);
        wr(idx, 0, base_w(2'($urandom), mk, 8'd0, blo));
        wr(idx, 1, lim_w(3'($urandom), 3'($urandom), 8'd0, blo + 16'($urandom % 300)));
        if (($urandom % 4) == 0)
          wr(0, 2, swap_w(1'($urandom), 7'($urandom % 16), 7'($urandom % 32), 7'($urandom % 8)));
        chk(cfg_err == m_err, "R8", "cfg_err random", cfg_err, m_err);
      end
      begin
        logic [47:0] a;
        a = {14'd0, 34'($urandom)} | ({48'd0, 32'($urandom % 4)} << 32);
        if (($urandom % 10) == 0) a = {16'd0, 32'($urandom)} << 16;
        if (n % 3 == 0) wr_dec(IW'($urandom % NR), 2'd3, $urandom, a);
        else dec(a, "R3");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule